// File: doc/BRIEF.md
# Parallel category-coalescing slot allocator

This block hands out a small pool of shared slots to a set of request lanes in a single combinational pass. Each lane carries a request bit, a broadcast bit, a category code and a swap bit. A global mode bit gates both the requests and the broadcasts. The result is the same as a greedy serial scan over the lanes. In that scan, the first enabled lane of a category claims the lowest free slot, every other lane of that category is given the same slot, and broadcast lanes are overwritten by every new claim.

The network has no loop-carried chain. An all-pairs category comparison picks one leader per category. A log-depth prefix count over the leader flags gives each leader its slot rank. AND-OR gathers then return a slot index and a done flag to each lane, and fill a per-slot field table. A parameter reverses the scan order. A second parameter selects a forward-sharing variant, in which a leader's slot also reaches later same-category lanes that are not enabled.

Top module: `slot_alloc`

## Requirements
- R1: With `mode_i` low, every lane reports slot 0 and done 0, and the whole field table is zero, whatever the other inputs are.
- R2: With `ORDER = SCAN_DOWN`, lanes are scanned from the highest index to the lowest, so the highest enabled lane claims slot 0.
- R3: Each new leader claims the lowest free slot. Leaders receive slots 0, 1, 2, ... in scan order, never counting down from the top.
- R4: Every enabled lane whose category equals the category of a leader gets that leader's slot and done 1.
- R5: A broadcast lane (`bcast_i & mode_i`) ends with the last slot that was claimed and done 1, provided at least one slot was claimed.
- R6: A lane that receives no slot reports slot 0 and done 0.
- R7: With `SHARE = SHARE_FORWARD`, a lane that is not enabled but comes later in the scan than a leader of its category gets that leader's slot and done 1. A lane of that category that comes earlier in the scan stays at done 0. With `SHARE_ENABLED`, a lane that is not enabled never shares a slot.
- R8: For each claimed slot j and each l in 0..3, field entry j*4+l, at bits [(j*4+l)*FW +: FW] with FW = CAT_W+2, holds {leader category, l[1:0]} XOR (leader swap bit << 1). The entries of unclaimed slots are zero.
- R9: A would-be leader whose rank is SLOTS or more gets no slot. It and the other enabled lanes of its category report slot 0 and done 0.
- R10: For random inputs, all outputs equal those of the serial first-fit scan. This holds for 8 lanes with 4 slots and for 16 lanes with 8 slots, and for both scan orders and both sharing variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | Global gate for requests and broadcasts |
| req_i | input | LANES | Per-lane request |
| bcast_i | input | LANES | Per-lane broadcast flag |
| cat_i | input | LANES*CAT_W | Category code of lane i at bits [i*CAT_W +: CAT_W] |
| swap_i | input | LANES | Per-lane swap bit folded into the field table |
| slot_o | output | LANES*SW | Binary slot index of lane i at bits [i*SW +: SW], SW = clog2(SLOTS) |
| done_o | output | LANES | Lane received a slot |
| field_o | output | SLOTS*4*FW | Per-slot field table, four entries per slot |

## Verification
The in-line assertions check the internal invariants on every evaluation. The first enabled lane in scan order is always a leader. Ranks step by exactly one per candidate. The number of leaders never exceeds the slot budget. Each lane has at most one writing leader, and each slot has at most one owner. Properties that depend on the whole input picture can only be shown by the bench's scenarios against the serial model. These include broadcast overwrite order, forward sharing into disabled lanes, budget exhaustion and reversed scanning.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;

    typedef enum logic {
        SCAN_UP   = 1'b0,
        SCAN_DOWN = 1'b1
    } scan_dir_e;

    typedef enum logic {
        SHARE_ENABLED = 1'b0,
        SHARE_FORWARD = 1'b1
    } share_mode_e;

    function automatic int idx_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sa_lane_order.sv
module sa_lane_order #(
    parameter int N    = 8,
    parameter int EW   = 1,
    parameter bit FLIP = 1'b0
) (
    input  logic [N*EW-1:0] a_i,
    output logic [N*EW-1:0] y_o
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        if (FLIP) begin : g_rev
            assign y_o[g*EW +: EW] = a_i[(N-1-g)*EW +: EW];
        end else begin : g_same
            assign y_o[g*EW +: EW] = a_i[g*EW +: EW];
        end
    end
endmodule

// File: rtl/sa_leader_find.sv
module sa_leader_find
    import slot_alloc_pkg::*;
#(
    parameter int          N     = 8,
    parameter int          CW    = 3,
    parameter share_mode_e SHARE = SHARE_ENABLED
) (
    input  logic [N-1:0]          en_i,
    input  logic [N-1:0]          bc_i,
    input  logic [N*CW-1:0]       cat_i,
    output logic [N-1:0]          cand_o,
    output logic [N-1:0][N-1:0]   reach_o
);
    logic [N-1:0][N-1:0] same;
    logic [N-1:0]        en_prior;
    logic [N-1:0]        elig;
    logic [N-1:0]        en_low;

    // all-pairs category comparison
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gk = 0; gk < N; gk++) begin : g_col
            assign same[gi][gk] = (cat_i[gi*CW +: CW] == cat_i[gk*CW +: CW]);
            if (SHARE == SHARE_FORWARD) begin : g_fwd
                if (gk >= gi) begin : g_ahead
                    assign reach_o[gi][gk] = same[gi][gk];
                end else begin : g_behind
                    assign reach_o[gi][gk] = 1'b0;
                end
            end else begin : g_en
                assign reach_o[gi][gk] = same[gi][gk] & en_i[gk];
            end
        end
    end

    // a broadcast lane seen after any claim is already done and never leads
    assign elig = en_i & ~(bc_i & en_prior);

    for (genvar gi = 0; gi < N; gi++) begin : g_cand
        if (gi == 0) begin : g_first
            assign en_prior[gi] = 1'b0;
            assign cand_o[gi]   = elig[gi];
        end else begin : g_rest
            assign en_prior[gi] = |en_i[gi-1:0];
            assign cand_o[gi]   = elig[gi] & ~|(elig[gi-1:0] & same[gi][gi-1:0]);
        end
    end

    assign en_low = en_i & (~en_i + 1'b1);

    always_comb begin
        if (!$isunknown({en_i, bc_i, cat_i})) begin
            p_first_enabled_leads_r3: assert ((en_i == '0) || ((en_low & cand_o) != '0));
        end
    end
endmodule

// File: rtl/sa_rank_scan.sv
module sa_rank_scan #(
    parameter int N   = 8,
    parameter int NB  = 4,
    parameter int CNT = 4,
    parameter int SW  = 2
) (
    input  logic [N-1:0]           cand_i,
    output logic [N-1:0][CNT-1:0]  rank_o,
    output logic [N-1:0]           lead_o,
    output logic                   any_o,
    output logic [SW-1:0]          last_o
);
    localparam int             LV   = $clog2(N);
    localparam logic [CNT-1:0] NB_L = CNT'(NB);

    logic [N-1:0][CNT-1:0] acc;
    logic [CNT-1:0]        total;
    logic [CNT-1:0]        claimed;

    // inclusive prefix count, doubling stride, updated high-to-low in place
    always_comb begin
        for (int g = 0; g < N; g++) begin
            acc[g] = CNT'(cand_i[g]);
        end
        for (int s = 0; s < LV; s++) begin
            for (int g = N - 1; g >= 0; g--) begin
                if (g >= (1 << s)) begin
                    acc[g] = acc[g] + acc[g - (1 << s)];
                end
            end
        end
    end

    always_comb begin
        rank_o[0] = '0;
        for (int g = 1; g < N; g++) begin
            rank_o[g] = acc[g-1];
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_lead
        assign lead_o[g] = cand_i[g] & (rank_o[g] < NB_L);
    end

    assign total   = acc[N-1];
    assign any_o   = |cand_i;
    assign claimed = (total > NB_L) ? NB_L : total;
    assign last_o  = SW'(claimed - CNT'(1));

    always_comb begin
        if (!$isunknown(cand_i)) begin
            p_budget_r9: assert ($countones(lead_o) <= NB);
        end
    end

    for (genvar g = 1; g < N; g++) begin : g_chk
        always_comb begin
            if (!$isunknown(cand_i)) begin
                p_rank_step_r3: assert (rank_o[g] == rank_o[g-1] + CNT'(cand_i[g-1]));
            end
        end
    end
endmodule

// File: rtl/sa_gather.sv
module sa_gather #(
    parameter int N   = 8,
    parameter int NB  = 4,
    parameter int CW  = 3,
    parameter int CNT = 4,
    parameter int SW  = 2,
    parameter int FW  = 5
) (
    input  logic [N-1:0]           lead_i,
    input  logic [N-1:0][CNT-1:0]  rank_i,
    input  logic [N-1:0][N-1:0]    reach_i,
    input  logic [N-1:0]           bc_i,
    input  logic [N*CW-1:0]        cat_i,
    input  logic [N-1:0]           swap_i,
    input  logic                   any_i,
    input  logic [SW-1:0]          last_i,
    output logic [N*SW-1:0]        slot_o,
    output logic [N-1:0]           done_o,
    output logic [NB*4*FW-1:0]     field_o
);
    // per-lane gather of the writing leader's rank
    for (genvar gk = 0; gk < N; gk++) begin : g_lane
        logic [N-1:0]  col;
        logic [SW-1:0] pick;
        logic          hit;
        logic [SW-1:0] lane_slot;
        logic          lane_done;

        always_comb begin
            col  = '0;
            pick = '0;
            for (int i = 0; i < N; i++) begin
                col[i] = lead_i[i] & reach_i[i][gk];
                pick   = pick | (rank_i[i][SW-1:0] & {SW{col[i]}});
            end
        end

        assign hit = |col;

        always_comb begin
            if (bc_i[gk] && any_i) begin
                lane_slot = last_i;
                lane_done = 1'b1;
            end else if (hit) begin
                lane_slot = pick;
                lane_done = 1'b1;
            end else begin
                lane_slot = '0;
                lane_done = 1'b0;
            end
        end

        assign slot_o[gk*SW +: SW] = lane_slot;
        assign done_o[gk]          = lane_done;

        always_comb begin
            if (!$isunknown({lead_i, reach_i})) begin
                p_single_writer_r4: assert ($onehot0(col));
                p_pick_in_range_r3: assert (!hit || (int'(pick) < NB));
            end
        end
    end

    // per-slot field table from the owning leader
    for (genvar gj = 0; gj < NB; gj++) begin : g_slot
        logic [N-1:0]  own;
        logic [CW-1:0] cat_pick;
        logic          swap_pick;
        logic          taken;

        always_comb begin
            own       = '0;
            cat_pick  = '0;
            swap_pick = 1'b0;
            for (int i = 0; i < N; i++) begin
                own[i]    = lead_i[i] & (rank_i[i] == CNT'(gj));
                cat_pick  = cat_pick | (cat_i[i*CW +: CW] & {CW{own[i]}});
                swap_pick = swap_pick | (swap_i[i] & own[i]);
            end
        end

        assign taken = |own;

        for (genvar gl = 0; gl < 4; gl++) begin : g_ent
            assign field_o[(gj*4+gl)*FW +: FW] =
                taken ? ({cat_pick, 2'(gl)} ^ (FW'(swap_pick) << 1)) : '0;
        end

        always_comb begin
            if (!$isunknown({lead_i, rank_i})) begin
                p_slot_owner_r8: assert ($onehot0(own));
            end
        end
    end
endmodule

// File: rtl/slot_alloc.sv
module slot_alloc
    import slot_alloc_pkg::*;
#(
    parameter int          LANES = 8,
    parameter int          SLOTS = 4,
    parameter int          CAT_W = 3,
    parameter scan_dir_e   ORDER = SCAN_UP,
    parameter share_mode_e SHARE = SHARE_ENABLED,
    localparam int         SW    = idx_bits(SLOTS),
    localparam int         FW    = CAT_W + 2
) (
    input  logic                    mode_i,
    input  logic [LANES-1:0]        req_i,
    input  logic [LANES-1:0]        bcast_i,
    input  logic [LANES*CAT_W-1:0]  cat_i,
    input  logic [LANES-1:0]        swap_i,
    output logic [LANES*SW-1:0]     slot_o,
    output logic [LANES-1:0]        done_o,
    output logic [SLOTS*4*FW-1:0]   field_o
);
    localparam int CNT  = cnt_bits(max_of(LANES, SLOTS));
    localparam bit FLIP = (ORDER == SCAN_DOWN);

    logic [LANES-1:0]            en_raw, bc_raw;
    logic [LANES-1:0]            en_s, bc_s, swap_s;
    logic [LANES*CAT_W-1:0]      cat_s;
    logic [LANES-1:0]            cand;
    logic [LANES-1:0][LANES-1:0] reach;
    logic [LANES-1:0][CNT-1:0]   rank;
    logic [LANES-1:0]            lead;
    logic                        any_claim;
    logic [SW-1:0]               last_slot;
    logic [LANES*SW-1:0]         slot_s;
    logic [LANES-1:0]            done_s;

    assign en_raw = req_i   & {LANES{mode_i}};
    assign bc_raw = bcast_i & {LANES{mode_i}};

    sa_lane_order #(.N(LANES), .EW(1), .FLIP(FLIP)) u_ord_en (.a_i(en_raw), .y_o(en_s));
    sa_lane_order #(.N(LANES), .EW(1), .FLIP(FLIP)) u_ord_bc (.a_i(bc_raw), .y_o(bc_s));
    sa_lane_order #(.N(LANES), .EW(1), .FLIP(FLIP)) u_ord_sw (.a_i(swap_i), .y_o(swap_s));
    sa_lane_order #(.N(LANES), .EW(CAT_W), .FLIP(FLIP)) u_ord_cat (.a_i(cat_i), .y_o(cat_s));

    sa_leader_find #(.N(LANES), .CW(CAT_W), .SHARE(SHARE)) u_leader (
        .en_i   (en_s),
        .bc_i   (bc_s),
        .cat_i  (cat_s),
        .cand_o (cand),
        .reach_o(reach)
    );

    sa_rank_scan #(.N(LANES), .NB(SLOTS), .CNT(CNT), .SW(SW)) u_rank (
        .cand_i(cand),
        .rank_o(rank),
        .lead_o(lead),
        .any_o (any_claim),
        .last_o(last_slot)
    );

    sa_gather #(.N(LANES), .NB(SLOTS), .CW(CAT_W), .CNT(CNT), .SW(SW), .FW(FW)) u_gather (
        .lead_i (lead),
        .rank_i (rank),
        .reach_i(reach),
        .bc_i   (bc_s),
        .cat_i  (cat_s),
        .swap_i (swap_s),
        .any_i  (any_claim),
        .last_i (last_slot),
        .slot_o (slot_s),
        .done_o (done_s),
        .field_o(field_o)
    );

    sa_lane_order #(.N(LANES), .EW(SW), .FLIP(FLIP)) u_ord_slot (.a_i(slot_s), .y_o(slot_o));
    sa_lane_order #(.N(LANES), .EW(1), .FLIP(FLIP)) u_ord_done (.a_i(done_s), .y_o(done_o));
endmodule

// File: tb/test_slot_alloc.sv
`timescale 1ns/1ps
module test_slot_alloc;
    import slot_alloc_pkg::*;

    localparam real HALF = 4.0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(HALF) clk = ~clk;

    logic        mode;
    logic [15:0] req, bc, sw;
    logic [23:0] cat8;
    logic [63:0] cat16;

    logic [15:0]  s0, s2, s3;
    logic [7:0]   d0, d2, d3;
    logic [79:0]  f0, f2, f3;
    logic [47:0]  s1;
    logic [15:0]  d1;
    logic [191:0] f1;

    slot_alloc #(.LANES(8), .SLOTS(4), .CAT_W(3)) i_slot_alloc (
        .mode_i(mode), .req_i(req[7:0]), .bcast_i(bc[7:0]), .cat_i(cat8),
        .swap_i(sw[7:0]), .slot_o(s0), .done_o(d0), .field_o(f0));
    slot_alloc #(.LANES(16), .SLOTS(8), .CAT_W(4)) i_slot_alloc_wide (
        .mode_i(mode), .req_i(req), .bcast_i(bc), .cat_i(cat16),
        .swap_i(sw), .slot_o(s1), .done_o(d1), .field_o(f1));
    slot_alloc #(.LANES(8), .SLOTS(4), .CAT_W(3), .ORDER(SCAN_DOWN)) i_slot_alloc_down (
        .mode_i(mode), .req_i(req[7:0]), .bcast_i(bc[7:0]), .cat_i(cat8),
        .swap_i(sw[7:0]), .slot_o(s2), .done_o(d2), .field_o(f2));
    slot_alloc #(.LANES(8), .SLOTS(4), .CAT_W(3), .SHARE(SHARE_FORWARD)) i_slot_alloc_fwd (
        .mode_i(mode), .req_i(req[7:0]), .bcast_i(bc[7:0]), .cat_i(cat8),
        .swap_i(sw[7:0]), .slot_o(s3), .done_o(d3), .field_o(f3));

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int e_slot [16];
    bit e_done [16];
    int e_fld  [32];

    // serial first-fit reference
    task automatic ref_run(input int n, input int nb, input int cw,
                           input bit desc, input bit fwd, input logic [63:0] cat);
        bit taken [8];
        int ci, ck, i;
        for (int k = 0; k < 16; k++) begin e_slot[k] = 0; e_done[k] = 0; end
        for (int e = 0; e < 32; e++) e_fld[e] = 0;
        for (int j = 0; j < 8; j++) taken[j] = 0;
        for (int step = 0; step < n; step++) begin
            i = desc ? (n - 1 - step) : step;
            if (req[i] && mode) begin
                for (int j = 0; j < nb; j++) begin
                    if (!taken[j] && !e_done[i]) begin
                        e_slot[i] = j; e_done[i] = 1; taken[j] = 1;
                        ci = int'((cat >> (i*cw)) & ((64'd1 << cw) - 1));
                        for (int l = 0; l < 4; l++)
                            e_fld[j*4+l] = (ci*4 + l) ^ (int'(sw[i]) << 1);
                        for (int k = 0; k < n; k++) begin
                            ck = int'((cat >> (k*cw)) & ((64'd1 << cw) - 1));
                            if (fwd) begin
                                if ((ck == ci && (desc ? (k <= i) : (k >= i))) || (bc[k] && mode)) begin
                                    e_slot[k] = j; e_done[k] = 1;
                                end
                            end else begin
                                if ((k != i && req[k] && mode && ck == ci) || (bc[k] && mode)) begin
                                    e_slot[k] = j; e_done[k] = 1;
                                end
                            end
                        end
                    end
                end
            end
        end
    endtask

    function automatic int act_slot(input int cfg, input int k);
        case (cfg)
            0: return int'(s0[k*2 +: 2]);
            1: return int'(s1[k*3 +: 3]);
            2: return int'(s2[k*2 +: 2]);
            default: return int'(s3[k*2 +: 2]);
        endcase
    endfunction

    function automatic int act_done(input int cfg, input int k);
        case (cfg)
            0: return int'(d0[k]);
            1: return int'(d1[k]);
            2: return int'(d2[k]);
            default: return int'(d3[k]);
        endcase
    endfunction

    function automatic int act_fld(input int cfg, input int e);
        case (cfg)
            0: return int'(f0[e*5 +: 5]);
            1: return int'(f1[e*6 +: 6]);
            2: return int'(f2[e*5 +: 5]);
            default: return int'(f3[e*5 +: 5]);
        endcase
    endfunction

    task automatic cmp_cfg(input string lbl, input int cfg);
        int n, nb;
        bit ok;
        n  = (cfg == 1) ? 16 : 8;
        nb = (cfg == 1) ? 8 : 4;
        if (cfg == 1) ref_run(16, 8, 4, 1'b0, 1'b0, cat16);
        else          ref_run(8, 4, 3, cfg == 2, cfg == 3, {40'd0, cat8});
        ok = 1'b1;
        for (int k = 0; k < n; k++) begin
            if (ok && (act_slot(cfg, k) != e_slot[k] || act_done(cfg, k) != int'(e_done[k]))) begin
                $display("FAIL %s cfg%0d lane %0d slot/done actual %0d/%0d expected %0d/%0d",
                         lbl, cfg, k, act_slot(cfg, k), act_done(cfg, k), e_slot[k], e_done[k]);
                ok = 1'b0;
            end
        end
        for (int e = 0; e < nb*4; e++) begin
            if (ok && act_fld(cfg, e) != e_fld[e]) begin
                $display("FAIL %s cfg%0d field %0d actual %0d expected %0d",
                         lbl, cfg, e, act_fld(cfg, e), e_fld[e]);
                ok = 1'b0;
            end
        end
        checks++;
        if (!ok) errors++;
    endtask

    task automatic run_all(input string lbl);
        for (int c = 0; c < 4; c++) cmp_cfg(lbl, c);
    endtask

    task automatic chk(input string lbl, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", lbl, act, exp);
        end
    endtask

    task automatic put_cat(input int i, input int v);
        cat8[i*3 +: 3]  = 3'(v);
        cat16[i*4 +: 4] = 4'(v);
    endtask

    task automatic clear_in();
        mode = 1'b1; req = '0; bc = '0; sw = '0;
        for (int i = 0; i < 16; i++) put_cat(i, 7 - (i % 8));
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        void'($urandom(32'h5A17));
        clear_in();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: mode low masks everything
        clear_in(); mode = 1'b0; req = '1; bc = '1; sw = '1;
        settle();
        chk("R1 done", int'(d0), 0);
        chk("R1 slot", int'(s0), 0);
        chk("R1 field", int'(f0 != '0), 0);
        run_all("R1");

        // R3: ascending leaders take 0,1,2
        @(negedge clk); clear_in();
        req[2:0] = 3'b111; put_cat(0, 5); put_cat(1, 1); put_cat(2, 6);
        settle();
        chk("R3 lane0", act_slot(0, 0), 0);
        chk("R3 lane1", act_slot(0, 1), 1);
        chk("R3 lane2", act_slot(0, 2), 2);
        run_all("R3");

        // R2: descending scan
        @(negedge clk); clear_in();
        req[0] = 1'b1; req[7] = 1'b1; put_cat(0, 1); put_cat(7, 2);
        settle();
        chk("R2 lane7 down", act_slot(2, 7), 0);
        chk("R2 lane0 down", act_slot(2, 0), 1);
        chk("R2 lane0 up", act_slot(0, 0), 0);
        run_all("R2");

        // R4: category sharing
        @(negedge clk); clear_in();
        req[1] = 1'b1; req[3] = 1'b1; req[5] = 1'b1;
        put_cat(1, 4); put_cat(3, 2); put_cat(5, 4);
        settle();
        chk("R4 lane5 slot", act_slot(0, 5), 0);
        chk("R4 lane5 done", act_done(0, 5), 1);
        chk("R4 lane3 slot", act_slot(0, 3), 1);
        run_all("R4");

        // R5 and R6: broadcast gets last slot, idle lane stays zero
        @(negedge clk); clear_in();
        req[2:0] = 3'b111; put_cat(0, 1); put_cat(1, 2); put_cat(2, 3);
        bc[6] = 1'b1;
        settle();
        chk("R5 bcast slot", act_slot(0, 6), 2);
        chk("R5 bcast done", act_done(0, 6), 1);
        chk("R6 idle slot", act_slot(0, 4), 0);
        chk("R6 idle done", act_done(0, 4), 0);
        run_all("R5");

        // R7: forward sharing into a disabled lane
        @(negedge clk); clear_in();
        req[0] = 1'b1; req[2] = 1'b1; put_cat(0, 7); put_cat(2, 3);
        put_cat(1, 3); put_cat(6, 3);
        settle();
        chk("R7 fwd lane6 slot", act_slot(3, 6), 1);
        chk("R7 fwd lane6 done", act_done(3, 6), 1);
        chk("R7 fwd lane1 done", act_done(3, 1), 0);
        chk("R7 std lane6 done", act_done(0, 6), 0);
        run_all("R7");

        // R8: field table of slot 0, slot 1 empty
        @(negedge clk); clear_in();
        req[0] = 1'b1; put_cat(0, 2); sw[0] = 1'b1;
        settle();
        chk("R8 e0", act_fld(0, 0), 10);
        chk("R8 e1", act_fld(0, 1), 11);
        chk("R8 e2", act_fld(0, 2), 8);
        chk("R8 e3", act_fld(0, 3), 9);
        chk("R8 e4 empty", act_fld(0, 4), 0);
        run_all("R8");

        // R9: budget exhausted
        @(negedge clk); clear_in();
        req[5:0] = 6'b111111;
        for (int i = 0; i < 6; i++) put_cat(i, i);
        settle();
        chk("R9 lane3 slot", act_slot(0, 3), 3);
        chk("R9 lane4 done", act_done(0, 4), 0);
        chk("R9 lane5 slot", act_slot(0, 5), 0);
        chk("R9 lane5 done", act_done(0, 5), 0);
        run_all("R9");

        // R10: random against the serial model
        for (int v = 0; v < 2000; v++) begin
            int lim;
            @(negedge clk);
            mode = ($urandom % 8) != 0;
            req  = (v % 3 == 0) ? 16'($urandom) & 16'($urandom) : 16'($urandom);
            bc   = 16'($urandom) & 16'($urandom) & 16'($urandom);
            sw   = 16'($urandom);
            lim  = $urandom_range(1, 15);
            for (int i = 0; i < 16; i++) begin
                cat8[(i%8)*3 +: 3] = 3'($urandom_range(0, lim));
                cat16[i*4 +: 4]    = 4'($urandom_range(0, lim));
            end
            #1;
            run_all("R10");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(HALF * 2.0 * 150000.0);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule